// File: doc/BRIEF.md
# Quarter-Wave Compressed Sine Lookup

This block turns a phase word into a signed sine amplitude that covers a whole period, while its table holds samples for only the first quarter of the wave. The two top bits of the phase select one of four quadrants: rising from 0 to π/2, falling from π/2 to π, falling below zero from π to 3π/2, and rising back from 3π/2 to 2π. The remaining bits index the quarter-wave table. For a given table size this gives four times as many points per period as a full-period table.

In the second and fourth quadrants the table index is the bitwise complement of the low phase bits, which reflects the quarter wave in time. In the two quadrants where the most significant phase bit is set, the looked-up magnitude is negated. Because the index is complemented rather than subtracted from the quadrant length, every sample sits at a half-step offset and no sample repeats at a quadrant boundary. The table contents are computed when the design is elaborated. A phase accumulator upstream feeds the block one phase per clock. The block does no scaling.

The block has no control states. Data moves through two fixed register stages. Stage one registers the converted address and the quadrant. Stage two registers the signed amplitude.

Top module: `qw_sine_lut`

## Requirements
- R1: While rst_n is low, amp_o reads 0 whatever phase_i carries.
- R2: For quadrant code 00 (phase_i[12:11]), amp_o equals +T[phase_i[10:0]], where T is the stored table.
- R3: For quadrant code 01, amp_o equals +T[~phase_i[10:0]] (address complemented).
- R4: For quadrant code 10, amp_o equals −T[phase_i[10:0]].
- R5: For quadrant code 11, amp_o equals −T[~phase_i[10:0]].
- R6: A phase presented before clock edge k appears on amp_o right after edge k+1. After edge k alone, amp_o still shows the previous result.
- R7: T[i] = round(255·sin(π/2·(i+0.5)/2048)) for i in 0..2047. So T[0]=0 and T[2047]=255.
- R8: Adjacent quadrants mirror exactly: amp_o for phase p in quadrant 00 equals amp_o for 4095−p, and amp_o for p+4096 equals −amp_o for p.
- R9: A new phase accepted on every clock edge gives a new, correct result on every edge, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_i | input | 13 | Phase: [12:11] quadrant, [10:0] table index |
| amp_o | output | 9 | Signed two's-complement amplitude, range −255..255 |

## Verification
A fault in the stage-one quadrant or address register shows up two edges after the phase is applied. It appears either as a wrong sign or as a sample taken from the mirror position, and a value near a quadrant boundary makes it large, for example 0 instead of 255. A wrong table entry shows only when its own index is visited, so the bench sweeps the phase across all four quadrants in steps that land on many different indices. A stale or extra pipeline stage moves every result by one cycle, which the back-to-back stream and the explicit latency check both catch at once.

// File: rtl/qw_pkg.sv
`timescale 1ns/1ps
package qw_pkg;

    localparam real QW_PI = 3.14159265358979323846;

    typedef enum logic [1:0] {
        QD_RISE_POS = 2'b00,
        QD_FALL_POS = 2'b01,
        QD_FALL_NEG = 2'b10,
        QD_RISE_NEG = 2'b11
    } quad_e;

    // Quarter-wave sample at half-step offset, rounded to nearest.
    function automatic int unsigned qw_sample(input int idx, input int aw, input int mw);
        real ang;
        real full;
        ang  = QW_PI / 2.0 * (real'(idx) + 0.5) / real'(1 << aw);
        full = real'((1 << mw) - 1);
        return int'($rtoi(full * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/qw_addr_map.sv
`timescale 1ns/1ps
module qw_addr_map
    import qw_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W+1:0] phase_i,
    output logic [ADDR_W-1:0] addr_o,
    output quad_e             quad_o
);

    logic [ADDR_W-1:0] low_bits;
    logic              mirror;

    assign low_bits = phase_i[ADDR_W-1:0];
    assign mirror   = phase_i[ADDR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            quad_o <= QD_RISE_POS;
        end else begin
            quad_o <= quad_e'(phase_i[ADDR_W+1:ADDR_W]);
            addr_o <= mirror ? ~low_bits : low_bits;
        end
    end

    // R3
    mirror_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(phase_i[ADDR_W])) |-> ((addr_o ^ $past(phase_i[ADDR_W-1:0])) == '1));

    // R2
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(phase_i[ADDR_W])) |-> (addr_o == $past(phase_i[ADDR_W-1:0])));

    // R6
    quad_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (quad_o == $past(phase_i[ADDR_W+1:ADDR_W])));

endmodule

// File: rtl/qw_rom.sv
`timescale 1ns/1ps
module qw_rom
    import qw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int MAG_W  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [MAG_W-1:0]  mag_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [MAG_W-1:0] table_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        localparam int unsigned ENTRY = qw_sample(gi, ADDR_W, MAG_W);
        assign table_q[gi] = ENTRY[MAG_W-1:0];
    end

    assign mag_o = table_q[addr_i];

endmodule

// File: rtl/qw_amp_map.sv
`timescale 1ns/1ps
module qw_amp_map #(
    parameter int MAG_W = 8,
    parameter int OUT_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [MAG_W-1:0]        mag_i,
    input  logic                    neg_i,
    output logic signed [OUT_W-1:0] amp_o
);

    logic signed [OUT_W-1:0] pos_val;
    logic signed [OUT_W-1:0] sel_val;

    assign pos_val = signed'({{(OUT_W-MAG_W){1'b0}}, mag_i});
    assign sel_val = neg_i ? -pos_val : pos_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            amp_o <= '0;
        end else begin
            amp_o <= sel_val;
        end
    end

    // R4
    neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_o < 0) |-> $past(neg_i));

    // R2
    pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(neg_i)) |-> (amp_o >= 0));

    // R5
    mag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((amp_o < 0 ? -amp_o : amp_o) == signed'({{(OUT_W-MAG_W){1'b0}}, $past(mag_i)})));

endmodule

// File: rtl/qw_sine_lut.sv
`timescale 1ns/1ps
module qw_sine_lut
    import qw_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int MAG_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W+1:0]       phase_i,
    output logic signed [MAG_W:0]   amp_o
);

    localparam int OUT_W = MAG_W + 1;
    localparam int PEAK  = (1 << MAG_W) - 1;

    logic [ADDR_W-1:0] addr_s1;
    quad_e             quad_s1;
    logic [MAG_W-1:0]  mag_s1;
    logic              neg_s1;

    qw_addr_map #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_i),
        .addr_o  (addr_s1),
        .quad_o  (quad_s1)
    );

    qw_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
        .addr_i (addr_s1),
        .mag_o  (mag_s1)
    );

    assign neg_s1 = (quad_s1 == QD_FALL_NEG) || (quad_s1 == QD_RISE_NEG);

    qw_amp_map #(.MAG_W(MAG_W), .OUT_W(OUT_W)) u_amp (
        .clk   (clk),
        .rst_n (rst_n),
        .mag_i (mag_s1),
        .neg_i (neg_s1),
        .amp_o (amp_o)
    );

    // R1
    reset_zero_chk: assert property (@(posedge clk) !rst_n |-> (amp_o == 0));

    // R7
    amp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_o <= PEAK) && (amp_o >= -PEAK));

endmodule

// File: tb/test_qw_sine_lut.sv
`timescale 1ns/1ps
module test_qw_sine_lut;

    localparam int AW = 11;
    localparam int MW = 8;

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [AW+1:0]        phase = '0;
    logic signed [MW:0]   amp;
    logic                 drv_v = 1'b0;
    logic                 v_d1 = 1'b0;
    logic                 v_d2 = 1'b0;
    int                   checks = 0;
    int                   fails = 0;
    bit                   done = 1'b0;
    item_t                sb[$];

    always #10 clk = ~clk;

    qw_sine_lut #(.ADDR_W(AW), .MAG_W(MW)) i_qw_sine_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase),
        .amp_o   (amp)
    );

    function automatic int ref_tab(input int i);
        real a;
        a = 3.14159265358979323846 / 2.0 * (real'(i) + 0.5) / 2048.0;
        return int'($rtoi(255.0 * $sin(a) + 0.5));
    endfunction

    function automatic int ref_amp(input int p);
        int q;
        int lo;
        int m;
        q  = (p >> 11) & 3;
        lo = p & 2047;
        m  = ref_tab((q & 1) ? (2047 - lo) : lo);
        return (q & 2) ? -m : m;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: amp=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(input int p, input string tag);
        item_t it;
        @(negedge clk);
        phase = p[AW+1:0];
        drv_v = 1'b1;
        it.exp = ref_amp(p);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            drv_v = 1'b0;
        end
    endtask

    // Monitor: result for a phase driven before edge k is stable after edge k+1.
    always @(posedge clk) begin
        v_d1 <= drv_v;
        v_d2 <= v_d1;
        #2;
        if (v_d2 && rst_n) begin
            if (sb.size() == 0) begin
                check("R9 scoreboard underflow", 1, 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, int'(amp), it.exp);
            end
        end
    end

    initial begin
        // R1: reset holds output at zero even with a nonzero phase
        phase = 13'd2047;
        repeat (3) @(posedge clk);
        #2 check("R1 reset", int'(amp), 0);
        @(negedge clk);
        phase = 13'd6144;
        @(posedge clk);
        #2 check("R1 reset hold", int'(amp), 0);
        @(negedge clk);
        rst_n = 1'b1;
        phase = '0;
        idle(3);

        // R7 endpoints and R2..R5 quadrant corners
        push(0,    "R7 T[0]");
        push(2047, "R7 T[2047]");
        push(2048, "R3 q1 start");
        push(4095, "R3 q1 end");
        push(4096, "R4 q2 start");
        push(6143, "R4 q2 end");
        push(6144, "R5 q3 start");
        push(8191, "R5 q3 end");
        push(1024, "R2 mid");
        push(3072, "R3 mid");
        push(5120, "R4 mid");
        push(7168, "R5 mid");
        idle(4);

        // R6: latency, previous value held after one edge
        push(0, "R6 base");
        idle(3);
        @(negedge clk);
        phase = 13'd2047;
        @(posedge clk);
        #2 check("R6 after one edge", int'(amp), 0);
        @(posedge clk);
        #2 check("R6 after two edges", int'(amp), 255);
        idle(2);

        // R8: mirror and negation pairs
        for (int p = 3; p < 2048; p += 97) begin
            push(p, "R2 sweep");
            push(4095 - p, "R8 mirror");
            push(p + 4096, "R8 negate");
            push(8191 - p, "R5 sweep");
        end
        idle(4);

        // R9: continuous stream across the full period
        for (int p = 0; p < 8192; p += 37) begin
            push(p, "R9 stream");
        end
        idle(5);

        if (sb.size() != 0) check("R9 scoreboard leftover", sb.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: expired=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule